// File: doc/BRIEF.md
# Microcoded Multicycle Control Sequencer

This block steers a multicycle load/store processor datapath. A microaddress register selects one entry of a small microcode store in every clock cycle. Each entry is a 17-bit encoded word split into fields for the ALU operation, the two ALU operand selects, the register-file destination, the memory access, the instruction-register load, the PC update and the next-address choice. A decoder turns these fields into the individual control lines that the datapath needs.

Every instruction starts with a shared fetch step and a shared decode step. The decode step jumps through an opcode-indexed dispatch table to the first entry of the routine for that opcode. Each routine then steps through consecutive entries and returns to fetch. The ALU zero flag is combined with the conditional PC-write line, so the block also drives a single PC load strobe. Unlisted opcodes return to fetch directly after decode.

Top module: `useq_ctrl`

## Requirements
- R1: Reset is synchronous. While `rst` is high, `reg_write`, `mem_read`, `mem_write`, `ir_write`, `pc_write`, `pc_write_cond` and `pc_load` are all 0. In the first cycle after `rst` falls, the block presents the fetch step.
- R2: Fetch step: `alu_op`=00 (add), `alu_sel_a`=0 (PC), `alu_sel_b`=001 (constant 4), `mem_read`=1 with `addr_sel`=0 (PC address), `ir_write`=1, `pc_write`=1 with `pc_src`=0 (ALU result). The next cycle is the decode step.
- R3: Decode step: `alu_op`=00, `alu_sel_a`=0, `alu_sel_b`=011 (sign-extended immediate shifted left by 2), no write enable. The next step comes from the dispatch table.
- R4: The dispatch table sends opcode 0x23 to the load routine, 0x2B to store, 0x00 to register-register, 0x04 to branch-equal and 0x0D to OR-immediate. The opcode is sampled during the decode cycle.
- R5: Load routine, in order: (a) add with `alu_sel_a`=1 (rs) and `alu_sel_b`=010 (sign-extended immediate); (b) `mem_read`=1 with `addr_sel`=1 (ALU-output address); (c) `reg_write`=1 with `mem_to_reg`=1 and `reg_dst`=0 (rt). Then fetch.
- R6: Store routine, in order: (a) add rs and the sign-extended immediate; (b) `mem_write`=1 with `addr_sel`=1. Then fetch.
- R7: Register-register routine, in order: (a) `alu_op`=10 (function code) with `alu_sel_a`=1 and `alu_sel_b`=000 (rt); (b) `reg_write`=1 with `reg_dst`=1 (rd) and `mem_to_reg`=0. Then fetch.
- R8: OR-immediate routine, in order: (a) `alu_op`=11 (OR) with `alu_sel_a`=1 and `alu_sel_b`=100 (zero-extended immediate); (b) `reg_write`=1 with `reg_dst`=0 and `mem_to_reg`=0. Then fetch.
- R9: Branch-equal is a single step: `alu_op`=01 (subtract), `alu_sel_a`=1, `alu_sel_b`=000, `pc_write_cond`=1, `pc_src`=1 (registered ALU output). Then fetch.
- R10: An opcode that is not in the dispatch table returns to fetch in the cycle after decode.
- R11: `pc_load` is 1 exactly when `pc_write` is 1, or when `pc_write_cond` is 1 and `alu_zero` is 1. It follows `alu_zero` within the same cycle.
- R12: `mem_read` and `mem_write` are never 1 together, and `ir_write` is 1 only in the fetch step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU zero flag from the datapath |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function code, 11 OR |
| alu_sel_a | output | 1 | First ALU operand: 0 PC, 1 rs |
| alu_sel_b | output | 3 | Second ALU operand: 000 rt, 001 four, 010 sign-ext imm, 011 shifted sign-ext imm, 100 zero-ext imm |
| reg_write | output | 1 | Register file write enable |
| mem_to_reg | output | 1 | Register write data: 0 ALU output, 1 memory data |
| reg_dst | output | 1 | Destination register: 0 rt, 1 rd |
| mem_read | output | 1 | Memory read enable |
| mem_write | output | 1 | Memory write enable |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| ir_write | output | 1 | Instruction register load |
| pc_write | output | 1 | Unconditional PC write request |
| pc_write_cond | output | 1 | PC write request if the ALU result is zero |
| pc_src | output | 1 | PC source: 0 ALU result, 1 ALU output register |
| pc_load | output | 1 | Combined PC load strobe |

## Verification
Some properties are checked on every cycle: the write enables stay quiet during reset, fetch always moves on to decode, an unknown opcode returns to fetch, and the load opcode dispatches to its routine. The same cycle-by-cycle checks cover the exclusion of memory read and write, the restriction of instruction-register loads to fetch, and the rule that `pc_load` may only rise from one of the two PC write requests. Only the bench scenarios show the full field values of each routine step in their order. They also show the branch strobe tracking the zero flag inside one cycle, and recovery when reset arrives in the middle of a load.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int UA_W  = 4;
  localparam int OP_W  = 6;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_FUNC, ALU_OR} alu_f_e;
  typedef enum logic {SA_PC, SA_RS} src1_f_e;
  typedef enum logic [2:0] {SB_RT, SB_FOUR, SB_SEXT, SB_SEXT_SH2, SB_ZEXT} src2_f_e;
  typedef enum logic [1:0] {DST_NONE, DST_RD_ALU, DST_RT_ALU, DST_RT_MEM} dst_f_e;
  typedef enum logic [2:0] {MEM_NONE, MEM_RD_PC, MEM_RD_ALU, MEM_WR_ALU} mem_f_e;
  typedef enum logic [2:0] {PCW_NONE, PCW_ALU, PCW_COND} pcw_f_e;
  typedef enum logic [1:0] {SEQ_FETCH, SEQ_DISPATCH, SEQ_NEXT} seq_f_e;

  // 2+1+3+2+3+1+3+2 = 17 bits
  typedef struct packed {
    alu_f_e  alu;
    src1_f_e src1;
    src2_f_e src2;
    dst_f_e  dst;
    mem_f_e  mem;
    logic    irw;
    pcw_f_e  pcw;
    seq_f_e  seq;
  } uword_t;

  // microaddress map
  localparam logic [UA_W-1:0] UA_FETCH  = 4'd0;
  localparam logic [UA_W-1:0] UA_DECODE = 4'd1;
  localparam logic [UA_W-1:0] UA_LD0    = 4'd2;
  localparam logic [UA_W-1:0] UA_LD1    = 4'd3;
  localparam logic [UA_W-1:0] UA_LD2    = 4'd4;
  localparam logic [UA_W-1:0] UA_ST0    = 4'd5;
  localparam logic [UA_W-1:0] UA_ST1    = 4'd6;
  localparam logic [UA_W-1:0] UA_RR0    = 4'd7;
  localparam logic [UA_W-1:0] UA_RR1    = 4'd8;
  localparam logic [UA_W-1:0] UA_BEQ    = 4'd9;
  localparam logic [UA_W-1:0] UA_ORI0   = 4'd10;
  localparam logic [UA_W-1:0] UA_ORI1   = 4'd11;

  // opcodes handled by the dispatch table
  localparam logic [OP_W-1:0] OPC_RR   = 6'h00;
  localparam logic [OP_W-1:0] OPC_BEQ  = 6'h04;
  localparam logic [OP_W-1:0] OPC_ORI  = 6'h0D;
  localparam logic [OP_W-1:0] OPC_LOAD = 6'h23;
  localparam logic [OP_W-1:0] OPC_STOR = 6'h2B;

  function automatic uword_t mk(alu_f_e a, src1_f_e s1, src2_f_e s2, dst_f_e d,
                                mem_f_e m, logic ir, pcw_f_e p, seq_f_e s);
    uword_t w;
    w.alu  = a;
    w.src1 = s1;
    w.src2 = s2;
    w.dst  = d;
    w.mem  = m;
    w.irw  = ir;
    w.pcw  = p;
    w.seq  = s;
    return w;
  endfunction

  // microprogram contents, one entry per microaddress
  function automatic uword_t ucode_word(int unsigned a);
    uword_t w;
    w = '0;
    case (a)
      32'd0:  w = mk(ALU_ADD,  SA_PC, SB_FOUR,     DST_NONE,   MEM_RD_PC,  1'b1, PCW_ALU,  SEQ_NEXT);
      32'd1:  w = mk(ALU_ADD,  SA_PC, SB_SEXT_SH2, DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_DISPATCH);
      32'd2:  w = mk(ALU_ADD,  SA_RS, SB_SEXT,     DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_NEXT);
      32'd3:  w = mk(ALU_ADD,  SA_PC, SB_RT,       DST_NONE,   MEM_RD_ALU, 1'b0, PCW_NONE, SEQ_NEXT);
      32'd4:  w = mk(ALU_ADD,  SA_PC, SB_RT,       DST_RT_MEM, MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH);
      32'd5:  w = mk(ALU_ADD,  SA_RS, SB_SEXT,     DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_NEXT);
      32'd6:  w = mk(ALU_ADD,  SA_PC, SB_RT,       DST_NONE,   MEM_WR_ALU, 1'b0, PCW_NONE, SEQ_FETCH);
      32'd7:  w = mk(ALU_FUNC, SA_RS, SB_RT,       DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_NEXT);
      32'd8:  w = mk(ALU_ADD,  SA_PC, SB_RT,       DST_RD_ALU, MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH);
      32'd9:  w = mk(ALU_SUB,  SA_RS, SB_RT,       DST_NONE,   MEM_NONE,   1'b0, PCW_COND, SEQ_FETCH);
      32'd10: w = mk(ALU_OR,   SA_RS, SB_ZEXT,     DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_NEXT);
      32'd11: w = mk(ALU_ADD,  SA_PC, SB_RT,       DST_RT_ALU, MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH);
      default: w = mk(ALU_ADD, SA_PC, SB_RT,       DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH);
    endcase
    return w;
  endfunction

  function automatic logic [UA_W-1:0] dispatch_of(logic [OP_W-1:0] opc);
    logic [UA_W-1:0] t;
    case (opc)
      OPC_RR:   t = UA_RR0;
      OPC_BEQ:  t = UA_BEQ;
      OPC_ORI:  t = UA_ORI0;
      OPC_LOAD: t = UA_LD0;
      OPC_STOR: t = UA_ST0;
      default:  t = UA_FETCH;
    endcase
    return t;
  endfunction

  function automatic logic [UA_W-1:0] next_uaddr(logic [UA_W-1:0] cur, seq_f_e s,
                                                  logic [UA_W-1:0] disp);
    logic [UA_W-1:0] n;
    case (s)
      SEQ_DISPATCH: n = disp;
      SEQ_NEXT:     n = cur + 1'b1;
      default:      n = '0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int UADDR_W = UA_W,
  localparam int DEPTH  = 1 << UADDR_W
) (
  input  logic [UADDR_W-1:0] upc,
  output uword_t             word
);

  uword_t rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign rom[g] = ucode_word(g);
  end

  assign word = rom[upc];

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int OPC_W   = OP_W,
  parameter int UADDR_W = UA_W
) (
  input  logic [OPC_W-1:0]   opcode,
  output logic [UADDR_W-1:0] target
);

  assign target = dispatch_of(opcode);

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int UADDR_W = UA_W
) (
  input  logic [UADDR_W-1:0] upc,
  input  seq_f_e             seq,
  input  logic [UADDR_W-1:0] disp_target,
  output logic [UADDR_W-1:0] upc_next
);

  assign upc_next = next_uaddr(upc, seq, disp_target);

endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  logic    rst,
  input  logic    alu_zero,
  input  alu_f_e  alu_f,
  input  src1_f_e src1_f,
  input  src2_f_e src2_f,
  input  dst_f_e  dst_f,
  input  mem_f_e  mem_f,
  input  logic    irw_f,
  input  pcw_f_e  pcw_f,
  output logic [1:0] alu_op,
  output logic       alu_sel_a,
  output logic [2:0] alu_sel_b,
  output logic       reg_write,
  output logic       mem_to_reg,
  output logic       reg_dst,
  output logic       mem_read,
  output logic       mem_write,
  output logic       addr_sel,
  output logic       ir_write,
  output logic       pc_write,
  output logic       pc_write_cond,
  output logic       pc_src,
  output logic       pc_load
);

  logic rw_raw, mr_raw, mw_raw, pw_raw, pwc_raw;
  logic live;

  assign live      = ~rst;
  assign alu_op    = alu_f;
  assign alu_sel_a = src1_f;
  assign alu_sel_b = src2_f;

  always_comb begin
    rw_raw     = 1'b0;
    mem_to_reg = 1'b0;
    reg_dst    = 1'b0;
    case (dst_f)
      DST_RD_ALU: begin rw_raw = 1'b1; reg_dst = 1'b1; end
      DST_RT_ALU: rw_raw = 1'b1;
      DST_RT_MEM: begin rw_raw = 1'b1; mem_to_reg = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    mr_raw   = 1'b0;
    mw_raw   = 1'b0;
    addr_sel = 1'b0;
    case (mem_f)
      MEM_RD_PC:  mr_raw = 1'b1;
      MEM_RD_ALU: begin mr_raw = 1'b1; addr_sel = 1'b1; end
      MEM_WR_ALU: begin mw_raw = 1'b1; addr_sel = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    pw_raw  = 1'b0;
    pwc_raw = 1'b0;
    pc_src  = 1'b0;
    case (pcw_f)
      PCW_ALU:  pw_raw = 1'b1;
      PCW_COND: begin pwc_raw = 1'b1; pc_src = 1'b1; end
      default: ;
    endcase
  end

  assign reg_write     = live & rw_raw;
  assign mem_read      = live & mr_raw;
  assign mem_write     = live & mw_raw;
  assign ir_write      = live & irw_f;
  assign pc_write      = live & pw_raw;
  assign pc_write_cond = live & pwc_raw;
  assign pc_load       = live & (pw_raw | (pwc_raw & alu_zero));

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int OPC_W   = OP_W,
  parameter int UADDR_W = UA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_zero,
  output logic [1:0]       alu_op,
  output logic             alu_sel_a,
  output logic [2:0]       alu_sel_b,
  output logic             reg_write,
  output logic             mem_to_reg,
  output logic             reg_dst,
  output logic             mem_read,
  output logic             mem_write,
  output logic             addr_sel,
  output logic             ir_write,
  output logic             pc_write,
  output logic             pc_write_cond,
  output logic             pc_src,
  output logic             pc_load
);

  logic [UADDR_W-1:0] upc;
  logic [UADDR_W-1:0] upc_next;
  logic [UADDR_W-1:0] disp_target;
  uword_t             word;

  always_ff @(posedge clk) begin
    if (rst) upc <= '0;
    else     upc <= upc_next;
  end

  useq_store #(.UADDR_W(UADDR_W)) u_store (
    .upc  (upc),
    .word (word)
  );

  useq_dispatch #(.OPC_W(OPC_W), .UADDR_W(UADDR_W)) u_dispatch (
    .opcode (opcode),
    .target (disp_target)
  );

  useq_next #(.UADDR_W(UADDR_W)) u_next (
    .upc         (upc),
    .seq         (word.seq),
    .disp_target (disp_target),
    .upc_next    (upc_next)
  );

  useq_decode u_decode (
    .rst           (rst),
    .alu_zero      (alu_zero),
    .alu_f         (word.alu),
    .src1_f        (word.src1),
    .src2_f        (word.src2),
    .dst_f         (word.dst),
    .mem_f         (word.mem),
    .irw_f         (word.irw),
    .pcw_f         (word.pcw),
    .alu_op        (alu_op),
    .alu_sel_a     (alu_sel_a),
    .alu_sel_b     (alu_sel_b),
    .reg_write     (reg_write),
    .mem_to_reg    (mem_to_reg),
    .reg_dst       (reg_dst),
    .mem_read      (mem_read),
    .mem_write     (mem_write),
    .addr_sel      (addr_sel),
    .ir_write      (ir_write),
    .pc_write      (pc_write),
    .pc_write_cond (pc_write_cond),
    .pc_src        (pc_src),
    .pc_load       (pc_load)
  );

endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
  import useq_pkg::*;
#(
  parameter int OPC_W   = OP_W,
  parameter int UADDR_W = UA_W
) (
  input logic               clk,
  input logic               rst,
  input logic [OPC_W-1:0]   opcode,
  input logic               alu_zero,
  input logic [UADDR_W-1:0] upc,
  input logic [1:0]         alu_op,
  input logic               reg_write,
  input logic               mem_read,
  input logic               mem_write,
  input logic               ir_write,
  input logic               pc_write,
  input logic               pc_write_cond,
  input logic               pc_load
);

  logic listed_opc;
  assign listed_opc = (opcode == OPC_RR)  || (opcode == OPC_BEQ) || (opcode == OPC_ORI) ||
                      (opcode == OPC_LOAD) || (opcode == OPC_STOR);

  // R1: enables quiet while reset is held
  always @(negedge clk) begin
    if (rst) begin
      a_r1_reset_quiet: assert (!(reg_write || mem_read || mem_write || ir_write ||
                                  pc_write || pc_write_cond || pc_load))
        else $error("enable active during reset");
    end
  end

  a_r1_fetch_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (upc == UA_FETCH));

  a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (rst)
    (upc == UA_FETCH) |=> (upc == UA_DECODE));

  a_r4_load_dispatch: assert property (@(posedge clk) disable iff (rst)
    (upc == UA_DECODE && opcode == OPC_LOAD) |=> (upc == UA_LD0));

  a_r10_unknown_to_fetch: assert property (@(posedge clk) disable iff (rst)
    (upc == UA_DECODE && !listed_opc) |=> (upc == UA_FETCH));

  a_r9_cond_with_sub: assert property (@(posedge clk) disable iff (rst)
    pc_write_cond |-> (alu_op == 2'b01));

  a_r11_load_needs_request: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (pc_write || pc_write_cond));

  a_r11_cond_blocked: assert property (@(posedge clk) disable iff (rst)
    (pc_write_cond && !alu_zero && !pc_write) |-> !pc_load);

  a_r12_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_read && mem_write));

  a_r12_ir_only_fetch: assert property (@(posedge clk) disable iff (rst)
    ir_write |-> (upc == UA_FETCH));

endmodule

bind useq_ctrl useq_ctrl_chk #(.OPC_W(OPC_W), .UADDR_W(UADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .opcode        (opcode),
  .alu_zero      (alu_zero),
  .upc           (upc),
  .alu_op        (alu_op),
  .reg_write     (reg_write),
  .mem_read      (mem_read),
  .mem_write     (mem_write),
  .ir_write      (ir_write),
  .pc_write      (pc_write),
  .pc_write_cond (pc_write_cond),
  .pc_load       (pc_load)
);

// File: tb/useq_ctrl_bench.sv
module useq_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic       alu_zero = 1'b0;
  logic [1:0] alu_op;
  logic       alu_sel_a;
  logic [2:0] alu_sel_b;
  logic reg_write, mem_to_reg, reg_dst, mem_read, mem_write, addr_sel;
  logic ir_write, pc_write, pc_write_cond, pc_src, pc_load;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  useq_ctrl u_useq_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
    .alu_op(alu_op), .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b),
    .reg_write(reg_write), .mem_to_reg(mem_to_reg), .reg_dst(reg_dst),
    .mem_read(mem_read), .mem_write(mem_write), .addr_sel(addr_sel),
    .ir_write(ir_write), .pc_write(pc_write), .pc_write_cond(pc_write_cond),
    .pc_src(pc_src), .pc_load(pc_load)
  );

  // vector: aluop[16:15] sa[14] sb[13:11] rw m2r rd mr mw ia irw pw pwc ps pl
  localparam logic [16:0] EN_MASK = 17'b00_0_000_1_0_0_1_1_0_1_1_1_0_1;
  localparam logic [16:0] ALL     = '1;

  function automatic logic [16:0] ctl(logic [1:0] op, logic sa, logic [2:0] sb,
      logic rw, logic m2r, logic rd, logic mr, logic mw, logic ia,
      logic irw, logic pw, logic pwc, logic ps, logic pl);
    return {op, sa, sb, rw, m2r, rd, mr, mw, ia, irw, pw, pwc, ps, pl};
  endfunction

  function automatic logic [16:0] actual();
    return {alu_op, alu_sel_a, alu_sel_b, reg_write, mem_to_reg, reg_dst,
            mem_read, mem_write, addr_sel, ir_write, pc_write, pc_write_cond,
            pc_src, pc_load};
  endfunction

  // expected step vectors
  function automatic logic [16:0] e_fetch();  return ctl(2'b00,0,3'b001, 0,0,0, 1,0,0, 1, 1,0,0, 1); endfunction
  function automatic logic [16:0] e_decode(); return ctl(2'b00,0,3'b011, 0,0,0, 0,0,0, 0, 0,0,0, 0); endfunction
  function automatic logic [16:0] e_addr();   return ctl(2'b00,1,3'b010, 0,0,0, 0,0,0, 0, 0,0,0, 0); endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_vec(string tag, logic [16:0] exp, logic [16:0] mask);
    logic [16:0] act;
    act = actual();
    checks++;
    if ((act & mask) !== (exp & mask)) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (mask %b)", tag, act, exp, mask);
    end
  endtask

  task automatic front(logic [5:0] opc, string tag);
    opcode = opc;
    #1;
    expect_vec({tag, " R2 fetch"}, e_fetch(), ALL);
    tick();
    expect_vec({tag, " R3 decode"}, e_decode(), ALL);
    tick();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick(); tick();
    expect_vec("R1 reset quiet", ctl(2'b00,0,3'b001, 0,0,0, 0,0,0, 0, 0,0,0, 0), ALL);
    rst = 1'b0;
    #1;
    expect_vec("R1 fetch after reset", e_fetch(), ALL);
  endtask

  task automatic t_load();
    front(6'h23, "load");
    expect_vec("R4 R5 load addr", e_addr(), ALL);
    tick();
    expect_vec("R5 load read", ctl(2'b00,0,3'b000, 0,0,0, 1,0,1, 0, 0,0,0, 0), ALL);
    tick();
    expect_vec("R5 load writeback", ctl(2'b00,0,3'b000, 1,1,0, 0,0,0, 0, 0,0,0, 0), ALL);
    tick();
    #1;
    expect_vec("R5 load returns", e_fetch(), ALL);
  endtask

  task automatic t_store();
    front(6'h2B, "store");
    expect_vec("R4 R6 store addr", e_addr(), ALL);
    tick();
    expect_vec("R6 R12 store write", ctl(2'b00,0,3'b000, 0,0,0, 0,1,1, 0, 0,0,0, 0), ALL);
    tick();
    #1;
    expect_vec("R6 store returns", e_fetch(), ALL);
  endtask

  task automatic t_rtype();
    front(6'h00, "rtype");
    expect_vec("R4 R7 rtype op", ctl(2'b10,1,3'b000, 0,0,0, 0,0,0, 0, 0,0,0, 0), ALL);
    tick();
    expect_vec("R7 rtype writeback", ctl(2'b00,0,3'b000, 1,0,1, 0,0,0, 0, 0,0,0, 0), ALL);
    tick();
    #1;
    expect_vec("R7 rtype returns", e_fetch(), ALL);
  endtask

  task automatic t_ori();
    front(6'h0D, "ori");
    expect_vec("R4 R8 ori op", ctl(2'b11,1,3'b100, 0,0,0, 0,0,0, 0, 0,0,0, 0), ALL);
    tick();
    expect_vec("R8 ori writeback", ctl(2'b00,0,3'b000, 1,0,0, 0,0,0, 0, 0,0,0, 0), ALL);
    tick();
    #1;
    expect_vec("R8 ori returns", e_fetch(), ALL);
  endtask

  task automatic t_beq();
    alu_zero = 1'b0;
    front(6'h04, "beq");
    alu_zero = 1'b1;
    #1;
    expect_vec("R4 R9 R11 beq taken", ctl(2'b01,1,3'b000, 0,0,0, 0,0,0, 0, 0,1,1, 1), ALL);
    alu_zero = 1'b0;
    #1;
    expect_vec("R9 R11 beq not taken", ctl(2'b01,1,3'b000, 0,0,0, 0,0,0, 0, 0,1,1, 0), ALL);
    tick();
    #1;
    expect_vec("R9 R11 beq returns, fetch load ignores zero", e_fetch(), ALL);
  endtask

  task automatic t_unknown();
    front(6'h3F, "unknown");
    expect_vec("R10 unknown back to fetch", e_fetch(), ALL);
    opcode = 6'h05;
    #1;
    expect_vec("R10 second fetch", e_fetch(), ALL);
    tick();
    tick();
    #1;
    expect_vec("R10 opcode 0x05 back to fetch", e_fetch(), ALL);
  endtask

  task automatic t_reset_mid();
    front(6'h23, "midreset");
    tick();
    rst = 1'b1;
    #1;
    expect_vec("R1 reset mid load quiet", '0, EN_MASK);
    tick();
    expect_vec("R1 reset held quiet", '0, EN_MASK);
    rst = 1'b0;
    #1;
    expect_vec("R1 fetch after mid reset", e_fetch(), ALL);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_load();
    t_store();
    t_rtype();
    t_ori();
    t_beq();
    t_unknown();
    t_reset_mid();
    t_load();
    finish_run();
  end

endmodule